// File: doc/BRIEF.md
# Magic Address Sequence Detector

This block sits beside an asynchronous-style SRAM controller and watches the accesses the controller completes. It looks for a fixed chain of six read addresses. When the chain is complete it asks a nonvolatile transfer engine either to save the array or to restore it. Each finished chip-enable cycle reaches the block as a one-cycle strobe, `acc_valid`. The strobe carries the 15-bit address and the level of the write-enable line, where `acc_wen` = 1 means a read.

The first five reads of the chain are a common prefix. The sixth read picks the action: one final key raises a save request and the other raises a restore request. A write anywhere in the chain aborts it, and so does a read to any address that is not the next expected one. While the supply is flagged low, a completed save chain is thrown away. The request pulse is registered and appears in the cycle after the sixth strobe.

The access input is a pure strobe. It has no ready signal, so there is no back-pressure. The block accepts every strobe in the cycle it arrives, and a producer must never hold `acc_valid` for more than the one cycle of a completed access. The control pins (`low_supply`, `xfer_busy`) and the request outputs are plain levels and pulses.

Top module: `magic_seq_detect`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `save_req` and `restore_req` are 0. Any progress through the chain is discarded, so a chain interrupted by reset cannot complete afterwards.
- R2: Six reads in order at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0 raise `save_req` for exactly one cycle. That cycle is the one after the clock edge that samples the sixth strobe.
- R3: The same five-read prefix followed by a read at 0x0C63 raises `restore_req` for exactly one cycle, in the same timing.
- R4: Only `acc_addr[13:0]` is compared. The value of `acc_addr[14]` changes no outcome.
- R5: A strobe with `acc_wen` = 0 (a write) aborts the chain, even when its address equals the expected key. Such a strobe never raises a request.
- R6: A read whose address is not the expected next key aborts the chain. If that read is at 0x0E38, it counts as the first step of a new chain.
- R7: A save chain completed while `low_supply` = 1 raises no `save_req` and still returns the block to idle. A restore chain is not affected by `low_supply`.
- R8: While `xfer_busy` = 1, the block sits idle. Strobes in those cycles are not counted and raise no request, and any partial chain is dropped.
- R9: Cycles with `acc_valid` = 0 between the reads of a chain do not disturb it.
- R10: After a request the block is idle, so a repeated final key alone raises nothing.
- R11: `save_req` and `restore_req` are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle strobe for a completed chip-enable access |
| acc_addr | input | 15 | Address of the access |
| acc_wen | input | 1 | Write-enable level: 1 = read, 0 = write |
| low_supply | input | 1 | Supply below switch threshold; blocks save requests |
| xfer_busy | input | 1 | Transfer engine busy; holds the detector idle |
| save_req | output | 1 | One-cycle request to save the array |
| restore_req | output | 1 | One-cycle request to restore the array |

## Verification
The bench aims at the points where a sloppy detector still looks right on the happy path.

- A write aimed at a correct key must abort the chain. A design that checks only the address would go on to fire.
- A stray 0x0E38 in the middle of a chain must restart it at step one. A design that just clears the chain would miss the next valid save.
- Address bit 14 must be ignored. A 15-bit compare would never match.
- A save chain under low supply must be consumed rather than left armed. Otherwise a lone final key would fire once the supply recovers.
- Busy cycles and reset must drop partial progress.
- Idle gaps must not drop it.
- A repeated final key right after a request must stay silent.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int ADDR_W     = 15;
  localparam int CMP_W      = 14;
  localparam int NUM_PREFIX = 5;
  localparam int STEP_W     = $clog2(NUM_PREFIX + 1);

  localparam logic [CMP_W-1:0] SAVE_KEY    = 14'h0FC0;
  localparam logic [CMP_W-1:0] RESTORE_KEY = 14'h0C63;

  // Ordered prefix keys; the order is the chain order.
  function automatic logic [CMP_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 14'h0E38;
      1:       prefix_key = 14'h31C7;
      2:       prefix_key = 14'h03E0;
      3:       prefix_key = 14'h3C1F;
      default: prefix_key = 14'h303F;
    endcase
  endfunction

  typedef enum logic [1:0] {
    FIN_NONE    = 2'd0,
    FIN_SAVE    = 2'd1,
    FIN_RESTORE = 2'd2
  } fin_e;
endpackage

// File: rtl/msd_key_match.sv
module msd_key_match
  import msd_pkg::*;
#(
  parameter int NKEYS = NUM_PREFIX,
  parameter int CW    = CMP_W
) (
  input  logic [CW-1:0]    addr_cmp,
  output logic [NKEYS-1:0] prefix_hit,
  output logic             save_hit,
  output logic             restore_hit
);
  for (genvar g = 0; g < NKEYS; g++) begin : g_prefix
    assign prefix_hit[g] = (addr_cmp == prefix_key(g));
  end

  assign save_hit    = (addr_cmp == SAVE_KEY);
  assign restore_hit = (addr_cmp == RESTORE_KEY);
endmodule

// File: rtl/msd_step_ctrl.sv
module msd_step_ctrl
  import msd_pkg::*;
#(
  parameter int NKEYS = NUM_PREFIX,
  parameter int SW    = STEP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             is_read,
  input  logic             busy,
  input  logic [NKEYS-1:0] prefix_hit,
  input  logic             save_hit,
  input  logic             restore_hit,
  output fin_e             finish
);
  localparam logic [SW-1:0] LAST = SW'(NKEYS);

  logic [SW-1:0] step_q, step_d;
  logic          expect_hit;

  always_comb begin
    expect_hit = 1'b0;
    for (int i = 0; i < NKEYS; i++) begin
      if (step_q == SW'(i)) expect_hit = prefix_hit[i];
    end
  end

  always_comb begin
    step_d = step_q;
    finish = FIN_NONE;
    if (busy) begin
      step_d = '0;
    end else if (strobe) begin
      if (!is_read) begin
        step_d = '0;
      end else if (step_q == LAST) begin
        if (save_hit) begin
          finish = FIN_SAVE;
          step_d = '0;
        end else if (restore_hit) begin
          finish = FIN_RESTORE;
          step_d = '0;
        end else begin
          step_d = prefix_hit[0] ? SW'(1) : '0;
        end
      end else if (expect_hit) begin
        step_d = step_q + SW'(1);
      end else begin
        step_d = prefix_hit[0] ? SW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end
endmodule

// File: rtl/msd_req_out.sv
module msd_req_out
  import msd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  fin_e finish,
  input  logic inhibit_save,
  output logic save_req,
  output logic restore_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      save_req    <= 1'b0;
      restore_req <= 1'b0;
    end else begin
      save_req    <= (finish == FIN_SAVE) && !inhibit_save;
      restore_req <= (finish == FIN_RESTORE);
    end
  end
endmodule

// File: rtl/magic_seq_detect.sv
module magic_seq_detect
  import msd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wen,
  input  logic              low_supply,
  input  logic              xfer_busy,
  output logic              save_req,
  output logic              restore_req
);
  logic [NUM_PREFIX-1:0] prefix_hit;
  logic                  save_hit, restore_hit;
  fin_e                  finish;
  logic                  unused_hi_bits;

  // Upper address bits take no part in the key compare.
  assign unused_hi_bits = ^acc_addr[ADDR_W-1:CMP_W];

  msd_key_match #(.NKEYS(NUM_PREFIX), .CW(CMP_W)) u_match (
    .addr_cmp    (acc_addr[CMP_W-1:0]),
    .prefix_hit  (prefix_hit),
    .save_hit    (save_hit),
    .restore_hit (restore_hit)
  );

  msd_step_ctrl #(.NKEYS(NUM_PREFIX), .SW(STEP_W)) u_step (
    .clk         (clk),
    .rst         (rst),
    .strobe      (acc_valid),
    .is_read     (acc_wen),
    .busy        (xfer_busy),
    .prefix_hit  (prefix_hit),
    .save_hit    (save_hit),
    .restore_hit (restore_hit),
    .finish      (finish)
  );

  msd_req_out u_out (
    .clk          (clk),
    .rst          (rst),
    .finish       (finish),
    .inhibit_save (low_supply),
    .save_req     (save_req),
    .restore_req  (restore_req)
  );
endmodule

// File: rtl/msd_checker.sv
module msd_checker (
  input logic clk,
  input logic rst,
  input logic acc_valid,
  input logic acc_wen,
  input logic low_supply,
  input logic xfer_busy,
  input logic save_req,
  input logic restore_req
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!save_req && !restore_req));

  // R11
  req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(save_req && restore_req));

  // R11
  save_single_chk: assert property (@(posedge clk) disable iff (rst)
    save_req |=> !save_req);

  // R11
  restore_single_chk: assert property (@(posedge clk) disable iff (rst)
    restore_req |=> !restore_req);

  // R5
  write_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_wen) |=> (!save_req && !restore_req));

  // R7
  low_supply_block_chk: assert property (@(posedge clk) disable iff (rst)
    low_supply |=> !save_req);

  // R8
  busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_busy |=> (!save_req && !restore_req));

  // R2
  save_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !save_req);
endmodule

bind magic_seq_detect msd_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_valid   (acc_valid),
  .acc_wen     (acc_wen),
  .low_supply  (low_supply),
  .xfer_busy   (xfer_busy),
  .save_req    (save_req),
  .restore_req (restore_req)
);

// File: tb/magic_seq_detect_tb.sv
module magic_seq_detect_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [14:0] acc_addr = '0;
  logic        acc_wen = 1'b1;
  logic        low_supply = 1'b0;
  logic        xfer_busy = 1'b0;
  logic        save_req, restore_req;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  localparam logic [14:0] K0 = 15'h0E38, K1 = 15'h31C7, K2 = 15'h03E0,
                          K3 = 15'h3C1F, K4 = 15'h303F,
                          KS = 15'h0FC0, KR = 15'h0C63;

  always #5 clk = ~clk;

  magic_seq_detect u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_wen(acc_wen), .low_supply(low_supply), .xfer_busy(xfer_busy),
    .save_req(save_req), .restore_req(restore_req)
  );

  // exp: 0 none, 1 save, 2 restore; checked 1 ns after the sampling edge
  task automatic drive(input logic v, input logic [14:0] a, input logic rd,
                       input logic lo, input logic bz, input logic r,
                       input int exp, input string tag);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_wen = rd;
    low_supply = lo; xfer_busy = bz; rst = r;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [14:0] a, input int exp, input string tag);
    drive(1'b1, a, 1'b1, 1'b0, 1'b0, 1'b0, exp, tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 0, tag);
  endtask

  task automatic prefix(input string tag);
    rd(K0, 0, tag); rd(K1, 0, tag); rd(K2, 0, tag); rd(K3, 0, tag); rd(K4, 0, tag);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      int e;
      int got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = (save_req ? 1 : 0) + (restore_req ? 2 : 0);
      total++;
      if (got != e) begin
        bad++;
        $display("FAIL %s: got=%0d expected=%0d", t, got, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R1 reset");
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R1 reset");
    idle("R1 after reset");

    // R2 save, then R11 single cycle
    prefix("R2 prefix"); rd(KS, 1, "R2 save"); idle("R11 one cycle");
    // R3 restore
    prefix("R3 prefix"); rd(KR, 2, "R3 restore"); idle("R11 one cycle");
    // R4 bit 14 set everywhere
    rd(K0 | 15'h4000, 0, "R4"); rd(K1 | 15'h4000, 0, "R4"); rd(K2 | 15'h4000, 0, "R4");
    rd(K3 | 15'h4000, 0, "R4"); rd(K4 | 15'h4000, 0, "R4"); rd(KS | 15'h4000, 1, "R4 save");
    idle("R4");

    // R5 write at key address mid chain
    rd(K0, 0, "R5"); rd(K1, 0, "R5"); rd(K2, 0, "R5");
    drive(1'b1, K3, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R5 write");
    rd(K4, 0, "R5"); rd(KS, 0, "R5 aborted");
    // R5 write of final key
    prefix("R5"); drive(1'b1, KS, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R5 write final");
    rd(KS, 0, "R5 after write");

    // R6 foreign read aborts
    rd(K0, 0, "R6"); rd(K1, 0, "R6"); rd(15'h1234, 0, "R6 foreign");
    rd(K2, 0, "R6"); rd(K3, 0, "R6"); rd(K4, 0, "R6"); rd(KS, 0, "R6 aborted");
    // R6 stray first key restarts at step one
    rd(K0, 0, "R6"); rd(K1, 0, "R6"); rd(K2, 0, "R6");
    rd(K0, 0, "R6 restart"); rd(K1, 0, "R6"); rd(K2, 0, "R6");
    rd(K3, 0, "R6"); rd(K4, 0, "R6"); rd(KS, 1, "R6 restart save");
    // R6 first key in final slot restarts
    prefix("R6"); rd(K0, 0, "R6 final slot");
    rd(K1, 0, "R6"); rd(K2, 0, "R6"); rd(K3, 0, "R6"); rd(K4, 0, "R6");
    rd(KR, 2, "R6 final slot restore");

    // R7 low supply blocks save and consumes chain
    prefix("R7");
    drive(1'b1, KS, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R7 save blocked");
    rd(KS, 0, "R7 consumed");
    prefix("R7");
    drive(1'b1, KR, 1'b1, 1'b1, 1'b0, 1'b0, 2, "R7 restore allowed");

    // R8 busy strobe drops chain
    rd(K0, 0, "R8"); rd(K1, 0, "R8"); rd(K2, 0, "R8");
    drive(1'b1, K3, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R8 busy strobe");
    rd(K4, 0, "R8"); rd(KS, 0, "R8 dropped");
    // R8 busy idle cycle drops chain
    rd(K0, 0, "R8"); rd(K1, 0, "R8");
    drive(1'b0, '0, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R8 busy idle");
    rd(K2, 0, "R8"); rd(K3, 0, "R8"); rd(K4, 0, "R8"); rd(KR, 0, "R8 dropped");
    // R8 busy on final strobe
    prefix("R8");
    drive(1'b1, KS, 1'b1, 1'b0, 1'b1, 1'b0, 0, "R8 busy final");

    // R9 idle gaps
    rd(K0, 0, "R9"); idle("R9"); idle("R9"); rd(K1, 0, "R9"); idle("R9");
    rd(K2, 0, "R9"); rd(K3, 0, "R9"); idle("R9"); rd(K4, 0, "R9"); idle("R9");
    rd(KS, 1, "R9 save");

    // R10 repeated final key
    rd(KS, 0, "R10 repeat save"); rd(KR, 0, "R10 repeat restore");
    prefix("R10"); rd(KR, 2, "R10"); rd(KR, 0, "R10 repeat restore");

    // R1 mid-chain reset
    rd(K0, 0, "R1"); rd(K1, 0, "R1"); rd(K2, 0, "R1");
    drive(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R1 mid reset");
    rd(K3, 0, "R1"); rd(K4, 0, "R1"); rd(KS, 0, "R1 chain lost");

    idle("end"); idle("end");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule